// File: doc/BRIEF.md
# Two-Level Page-Table Walker

This block resolves a translation miss by reading a two-level page table from untranslated physical memory. A miss hands it a 32-bit virtual address. The root page number of the current table comes from a processor register and is sampled at the same moment. The walker then issues at most two 4-byte entry reads over a valid/ready request port and a valid-only response port. The memory side may stall the request or delay the response by any number of cycles.

A walk ends in exactly one of two outcomes. A refill pulse carries the virtual page number, the physical page number and the low attribute bits of the final entry for loading into the TLB. A fault pulse carries the original virtual address and the table level that stopped the walk.

The address splits into three fields:
- bits 31:22 select the first-level entry;
- bits 21:12 select the second-level entry;
- bits 11:0 are the offset inside a 4 KB page.

An entry keeps its page number in bits 31:10. Its flags are: present in bit 0, read in bit 1, write in bit 2, user in bit 4 and dirty in bit 7. A present entry with both read and write clear points to a next-level table. A present entry with read or write set is a leaf.

The controller has seven states: ST_IDLE, ST_L1_REQ, ST_L1_WAIT, ST_L2_REQ, ST_L2_WAIT, ST_DONE and ST_FAULT.
- ST_IDLE moves to ST_L1_REQ when a miss is presented.
- ST_L1_REQ moves to ST_L1_WAIT when the request is accepted.
- ST_L1_WAIT moves to ST_L2_REQ on a pointer entry, or to ST_FAULT on any other entry.
- ST_L2_REQ moves to ST_L2_WAIT when the request is accepted.
- ST_L2_WAIT moves to ST_DONE on a leaf entry, or to ST_FAULT otherwise.
- ST_DONE and ST_FAULT each last one cycle and return to ST_IDLE.

Top module: `ptw_walker`

## Requirements
- R1: While reset is held and in the first cycle after it, busy, mem_req_valid, refill_valid and fault_valid are all 0.
- R2: The first read of a walk addresses root*4096 + va[31:22]*4, which is the concatenation {root, va[31:22], 2'b00}.
- R3: The second read addresses P*4096 + va[21:12]*4, where P is bits 31:10 of the first-level entry.
- R4: While mem_req_valid is 1 and mem_req_ready is 0, the next cycle keeps mem_req_valid at 1 and mem_req_addr unchanged.
- R5: If the second-level entry is a present leaf (bit 0 set, and bit 1 or bit 2 set), a single refill_valid pulse reports the following:
  - refill_vpn = va[31:12];
  - refill_ppn = entry bits 31:10;
  - refill_attr = entry bits 9:0.
- R6: A first-level entry with bit 0 clear ends the walk with a fault pulse. Only one memory read is made, fault_level is 0 and fault_vaddr equals the miss address.
- R7: A present first-level entry with bit 1 or bit 2 set is not supported as a leaf. It ends the walk with a fault at level 0 after one read.
- R8: A second-level entry with bit 0 clear, or with bits 1 and 2 both clear, ends the walk with a fault. fault_level is 1 and fault_vaddr equals the miss address.
- R9: busy is 1 from the cycle after a miss is taken through the result pulse, and 0 in the cycle after it. A miss presented while busy starts no walk and causes no read.
- R10: refill_valid and fault_valid are never 1 together, each lasts one cycle, and each walk produces exactly one of them.
- R11: The result is the same for any request stall or response latency.
- R12: The root page number and the virtual address are sampled when the miss is taken. Later changes to those inputs do not affect the walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | Translation miss presented |
| miss_vaddr | input | 32 | Virtual address of the missing access |
| root_ppn | input | 22 | Page number of the first-level table |
| busy | output | 1 | Walk in progress; misses are not taken |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 34 | Physical byte address of the entry |
| mem_rsp_valid | input | 1 | Entry data returned |
| mem_rsp_data | input | 32 | Entry data |
| refill_valid | output | 1 | Translation found (one-cycle pulse) |
| refill_vpn | output | 20 | Virtual page number of the refill |
| refill_ppn | output | 22 | Physical page number of the refill |
| refill_attr | output | 10 | Attribute bits 9:0 of the leaf entry |
| fault_valid | output | 1 | Page fault (one-cycle pulse) |
| fault_vaddr | output | 32 | Virtual address of the faulting access |
| fault_level | output | 1 | 0 = first level stopped the walk, 1 = second level |

## Verification
Some properties can be checked on every cycle. These cover the stability of a stalled request, the exclusivity and one-cycle width of the result pulses, busy covering every request and result, and the first read address matching the root and index sampled with the miss. Other behaviour only the bench scenarios can show: the second-level address derived from returned data, the choice between refill and fault at each level for each entry shape, and the fact that one read is made before an early fault. The scenarios also show that results do not depend on memory latency, and that misses or input changes during a walk are ignored.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_L1_REQ,
        ST_L1_WAIT,
        ST_L2_REQ,
        ST_L2_WAIT,
        ST_DONE,
        ST_FAULT
    } walk_state_e;

    localparam int PTE_PRESENT_BIT = 0;
    localparam int PTE_READ_BIT    = 1;
    localparam int PTE_WRITE_BIT   = 2;

endpackage

// File: rtl/ptw_pte_decode.sv
module ptw_pte_decode #(
    parameter int PTE_W = 32,
    parameter int PPN_W = 22
) (
    input  logic [PTE_W-1:0]       pte,
    output logic                   is_ptr,
    output logic                   is_leaf,
    output logic [PPN_W-1:0]       ppn,
    output logic [PTE_W-PPN_W-1:0] attr
);
    import ptw_pkg::*;

    logic present;
    logic any_perm;

    always_comb begin
        present  = pte[PTE_PRESENT_BIT];
        any_perm = pte[PTE_READ_BIT] | pte[PTE_WRITE_BIT];
        is_ptr   = present & ~any_perm;
        is_leaf  = present & any_perm;
        ppn      = pte[PTE_W-1 -: PPN_W];
        attr     = pte[PTE_W-PPN_W-1:0];
    end

endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
    parameter int PPN_W = 22,
    parameter int IDX_W = 10,
    parameter int OFF_W = 12,
    parameter int VPN_W = 20
) (
    input  logic                   sel_second,
    input  logic [PPN_W-1:0]       root_ppn,
    input  logic [PPN_W-1:0]       next_ppn,
    input  logic [VPN_W-1:0]       vpn,
    output logic [PPN_W+OFF_W-1:0] pte_addr
);
    localparam int ENTRY_SH = OFF_W - IDX_W;

    logic [IDX_W-1:0] idx_hi;
    logic [IDX_W-1:0] idx_lo;
    logic [PPN_W-1:0] base;
    logic [IDX_W-1:0] idx;

    always_comb begin
        idx_hi   = vpn[VPN_W-1 -: IDX_W];
        idx_lo   = vpn[IDX_W-1:0];
        base     = sel_second ? next_ppn : root_ppn;
        idx      = sel_second ? idx_lo : idx_hi;
        pte_addr = {base, idx, {ENTRY_SH{1'b0}}};
    end

endmodule

// File: rtl/ptw_walker.sv
module ptw_walker #(
    parameter int VA_W  = 32,
    parameter int OFF_W = 12,
    parameter int IDX_W = 10,
    parameter int PPN_W = 22,
    parameter int PTE_W = 32,
    localparam int VPN_W  = VA_W - OFF_W,
    localparam int PA_W   = PPN_W + OFF_W,
    localparam int ATTR_W = PTE_W - PPN_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              miss_valid,
    input  logic [VA_W-1:0]   miss_vaddr,
    input  logic [PPN_W-1:0]  root_ppn,
    output logic              busy,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [PA_W-1:0]   mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [PTE_W-1:0]  mem_rsp_data,
    output logic              refill_valid,
    output logic [VPN_W-1:0]  refill_vpn,
    output logic [PPN_W-1:0]  refill_ppn,
    output logic [ATTR_W-1:0] refill_attr,
    output logic              fault_valid,
    output logic [VA_W-1:0]   fault_vaddr,
    output logic              fault_level
);
    import ptw_pkg::*;

    walk_state_e state_q, state_d;

    logic [VA_W-1:0]   va_q;
    logic [PPN_W-1:0]  root_q;
    logic [PPN_W-1:0]  next_ppn_q;
    logic [PPN_W-1:0]  leaf_ppn_q;
    logic [ATTR_W-1:0] leaf_attr_q;
    logic              flt_lvl_q;

    logic              dec_ptr;
    logic              dec_leaf;
    logic [PPN_W-1:0]  dec_ppn;
    logic [ATTR_W-1:0] dec_attr;
    logic              sel_second;

    ptw_pte_decode #(.PTE_W(PTE_W), .PPN_W(PPN_W)) u_dec (
        .pte     (mem_rsp_data),
        .is_ptr  (dec_ptr),
        .is_leaf (dec_leaf),
        .ppn     (dec_ppn),
        .attr    (dec_attr)
    );

    ptw_addr_gen #(.PPN_W(PPN_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .VPN_W(VPN_W)) u_agen (
        .sel_second (sel_second),
        .root_ppn   (root_q),
        .next_ppn   (next_ppn_q),
        .vpn        (va_q[VA_W-1 -: VPN_W]),
        .pte_addr   (mem_req_addr)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (miss_valid)    state_d = ST_L1_REQ;
            ST_L1_REQ:  if (mem_req_ready) state_d = ST_L1_WAIT;
            ST_L1_WAIT: if (mem_rsp_valid) state_d = dec_ptr ? ST_L2_REQ : ST_FAULT;
            ST_L2_REQ:  if (mem_req_ready) state_d = ST_L2_WAIT;
            ST_L2_WAIT: if (mem_rsp_valid) state_d = dec_leaf ? ST_DONE : ST_FAULT;
            ST_DONE:                       state_d = ST_IDLE;
            ST_FAULT:                      state_d = ST_IDLE;
            default:                       state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            va_q        <= '0;
            root_q      <= '0;
            next_ppn_q  <= '0;
            leaf_ppn_q  <= '0;
            leaf_attr_q <= '0;
            flt_lvl_q   <= 1'b0;
        end else begin
            if (state_q == ST_IDLE && miss_valid) begin
                va_q   <= miss_vaddr;
                root_q <= root_ppn;
            end
            if (state_q == ST_L1_WAIT && mem_rsp_valid) begin
                next_ppn_q <= dec_ppn;
                flt_lvl_q  <= 1'b0;
            end
            if (state_q == ST_L2_WAIT && mem_rsp_valid) begin
                leaf_ppn_q  <= dec_ppn;
                leaf_attr_q <= dec_attr;
                flt_lvl_q   <= 1'b1;
            end
        end
    end

    always_comb begin
        busy          = (state_q != ST_IDLE);
        mem_req_valid = (state_q == ST_L1_REQ) || (state_q == ST_L2_REQ);
        sel_second    = (state_q == ST_L2_REQ);
        refill_valid  = (state_q == ST_DONE);
        fault_valid   = (state_q == ST_FAULT);
        refill_vpn    = va_q[VA_W-1 -: VPN_W];
        refill_ppn    = leaf_ppn_q;
        refill_attr   = leaf_attr_q;
        fault_vaddr   = va_q;
        fault_level   = flt_lvl_q;
    end

endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
    parameter int IDX_W = 10,
    parameter int PPN_W = 22,
    parameter int PA_W  = 34
) (
    input logic             clk,
    input logic             rst_n,
    input logic             miss_valid,
    input logic [IDX_W-1:0] miss_idx1,
    input logic [PPN_W-1:0] root_ppn,
    input logic             busy,
    input logic             mem_req_valid,
    input logic             mem_req_ready,
    input logic [PA_W-1:0]  mem_req_addr,
    input logic             refill_valid,
    input logic             fault_valid
);
    localparam int SH = PA_W - PPN_W - IDX_W;

    // R4
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R10
    one_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(refill_valid && fault_valid));

    // R10
    refill_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        refill_valid |=> !refill_valid);

    // R10
    fault_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_valid |=> !fault_valid);

    // R9
    busy_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid || refill_valid || fault_valid) |-> busy);

    // R2
    first_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && miss_valid) |=>
            (mem_req_valid && mem_req_addr == {$past(root_ppn), $past(miss_idx1), {SH{1'b0}}}));

endmodule

bind ptw_walker ptw_walker_chk #(.IDX_W(IDX_W), .PPN_W(PPN_W), .PA_W(PA_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .miss_valid    (miss_valid),
    .miss_idx1     (miss_vaddr[VA_W-1 -: IDX_W]),
    .root_ppn      (root_ppn),
    .busy          (busy),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .refill_valid  (refill_valid),
    .fault_valid   (fault_valid)
);

// File: tb/ptw_walker_tb.sv
module ptw_walker_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 7;

    localparam logic [31:0] V_VA   [NV] = '{32'h1234_5678, 32'hFFFF_F000, 32'h0000_0000,
                                           32'h0040_3000, 32'h8000_1ABC, 32'h7FC0_0FFF, 32'h0000_2000};
    localparam logic [21:0] V_ROOT [NV] = '{22'h00100, 22'h3FFFF, 22'h00000,
                                           22'h00020, 22'h00333, 22'h00010, 22'h00001};
    localparam logic [31:0] V_L1   [NV] = '{{22'h00200, 10'h001}, {22'h12345, 10'h001}, {22'h3FFFFF, 10'h000},
                                           {22'h00055, 10'h003}, {22'h00777, 10'h001}, {22'h00000, 10'h001},
                                           {22'h00123, 10'h011}};
    localparam logic [31:0] V_L2   [NV] = '{{22'h0ABCD, 10'h0C7}, {22'h3FFFFF, 10'h013}, {22'h00001, 10'h003},
                                           {22'h00001, 10'h003}, {22'h00001, 10'h000}, {22'h00042, 10'h001},
                                           {22'h00099, 10'h005}};
    localparam int          V_LAT  [NV] = '{0, 3, 1, 0, 5, 2, 1};
    localparam int          V_STL  [NV] = '{0, 2, 0, 1, 0, 3, 4};

    logic        clk = 0;
    logic        rst_n = 0;
    logic        miss_valid = 0;
    logic [31:0] miss_vaddr = '0;
    logic [21:0] root_ppn = '0;
    logic        busy;
    logic        mem_req_valid;
    logic        mem_req_ready = 0;
    logic [33:0] mem_req_addr;
    logic        mem_rsp_valid = 0;
    logic [31:0] mem_rsp_data = '0;
    logic        refill_valid;
    logic [19:0] refill_vpn;
    logic [21:0] refill_ppn;
    logic [9:0]  refill_attr;
    logic        fault_valid;
    logic [31:0] fault_vaddr;
    logic        fault_level;

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    logic [31:0] mem [logic [33:0]];
    logic [33:0] req_log [$];
    int cur_lat = 0;
    int cur_stall = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ptw_walker u_dut (.*);

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // memory model: stalls the request, then returns data after a latency
    initial begin
        bit pend = 0;
        int cnt = 0;
        int stall_c = 0;
        logic [33:0] a = '0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 0;
            if (mem_req_ready) begin
                req_log.push_back(a);
                mem_req_ready = 0;
                pend = 1;
                cnt = cur_lat;
            end else if (pend) begin
                if (cnt == 0) begin
                    mem_rsp_valid = 1;
                    mem_rsp_data = mem.exists(a) ? mem[a] : 32'h0;
                    pend = 0;
                    stall_c = cur_stall;
                end else cnt--;
            end else if (mem_req_valid) begin
                if (stall_c == 0) begin
                    mem_req_ready = 1;
                    a = mem_req_addr;
                end else stall_c--;
            end
        end
    end

    task automatic run_walk(input logic [31:0] va, input logic [21:0] root,
                            input logic [31:0] l1, input logic [31:0] l2,
                            input int lat, input int stl, input bit disturb, input string tag);
        logic [33:0] l1a, l2a;
        int kind, waited;
        bit got_r, got_f;
        l1a = {root, va[31:22], 2'b00};
        l2a = {l1[31:10], va[21:12], 2'b00};
        mem.delete();
        mem[l1a] = l1;
        mem[l2a] = l2;
        req_log.delete();
        cur_lat = lat;
        cur_stall = stl;
        if (!l1[0] || l1[1] || l1[2]) kind = 1;
        else if (!l2[0] || !(l2[1] || l2[2])) kind = 2;
        else kind = 0;

        @(negedge clk);
        miss_valid = 1; miss_vaddr = va; root_ppn = root;
        @(negedge clk);
        // R12: inputs change after the miss is taken
        miss_vaddr = ~va; root_ppn = ~root;
        miss_valid = disturb;
        waited = 0; got_r = 0; got_f = 0;
        while (waited < 500) begin
            if (refill_valid || fault_valid) begin
                got_r = refill_valid; got_f = fault_valid;
                break;
            end
            @(negedge clk);
            waited++;
        end
        miss_valid = 0;
        if (waited >= 500) check(0, tag, "walk timed out", 0, 1);

        if (kind == 0) begin
            check(got_r && !got_f, {tag, " R5"}, "refill expected", {got_r, got_f}, 2'b10);
            check(refill_vpn == va[31:12], {tag, " R5"}, "refill_vpn", refill_vpn, va[31:12]);
            check(refill_ppn == l2[31:10], {tag, " R5"}, "refill_ppn", refill_ppn, l2[31:10]);
            check(refill_attr == l2[9:0], {tag, " R5"}, "refill_attr", refill_attr, l2[9:0]);
        end else begin
            check(got_f && !got_r, {tag, (kind == 1) ? " R6 R7" : " R8"}, "fault expected",
                  {got_r, got_f}, 2'b01);
            check(fault_vaddr == va, {tag, " R6 R8"}, "fault_vaddr", fault_vaddr, va);
            check(fault_level == (kind == 2), {tag, " R6 R7 R8"}, "fault_level",
                  fault_level, (kind == 2));
        end
        check(req_log.size() == ((kind == 1) ? 1 : 2), {tag, " R6 R9"}, "read count",
              req_log.size(), (kind == 1) ? 1 : 2);
        if (req_log.size() >= 1)
            check(req_log[0] == l1a, {tag, " R2 R12"}, "first read address", req_log[0], l1a);
        if (req_log.size() >= 2)
            check(req_log[1] == l2a, {tag, " R3"}, "second read address", req_log[1], l2a);
        @(negedge clk);
        check(!refill_valid && !fault_valid, {tag, " R10"}, "pulse width",
              {refill_valid, fault_valid}, 0);
        check(!busy, {tag, " R9"}, "busy after result", busy, 0);
        repeat (4) @(negedge clk);
        check(!mem_req_valid && !busy, {tag, " R9"}, "no walk from ignored miss",
              {mem_req_valid, busy}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state while reset is held
        check(!busy && !mem_req_valid && !refill_valid && !fault_valid, "R1", "outputs in reset",
              {busy, mem_req_valid, refill_valid, fault_valid}, 0);
        rst_n = 1;
        @(negedge clk);
        check(!busy && !mem_req_valid && !refill_valid && !fault_valid, "R1", "outputs after reset",
              {busy, mem_req_valid, refill_valid, fault_valid}, 0);

        for (int i = 0; i < NV; i++)
            run_walk(V_VA[i], V_ROOT[i], V_L1[i], V_L2[i], V_LAT[i], V_STL[i], (i == 4),
                     $sformatf("vec%0d", i));

        // R11: the same translations under long stall and latency
        run_walk(V_VA[0], V_ROOT[0], V_L1[0], V_L2[0], 7, 5, 1'b0, "R11 long latency");
        run_walk(V_VA[5], V_ROOT[5], V_L1[5], V_L2[5], 6, 6, 1'b1, "R11 slow fault");

        // R9: a miss held high during a refill walk starts nothing
        run_walk(V_VA[1], V_ROOT[1], V_L1[1], V_L2[1], 2, 1, 1'b1, "R9 held miss");

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule